// File: doc/BRIEF.md
# Static Branch Predictor with One-Entry Reservation

This unit sits between the instruction queue and the fetch address logic. A branch at the head of the queue is steered by a fixed rule. The rule looks at the kind of branch, the sign of its displacement and a prediction-flip bit carried in the instruction. Fetch can then go on down the predicted stream at once. A conditional branch may leave the queue while its condition bit is still being computed. It then waits in a single reservation slot until the condition arrives.

When the condition bit is delivered, the parked branch is evaluated. A one-cycle resolve pulse reports the result. If the real direction differs from the guess, a mispredict flag comes with the address fetch must restart from. A conditional branch through a register whose target is not yet known cannot be guessed. The unit raises a wait flag and leaves that branch in the queue. A flush empties the slot silently.

Top module: `brResvUnit`

## Requirements
- R1: For a conditional relative branch (kind 2'b00) whose displacement is negative (sign bit 1), the prediction is taken when the flip bit is 0 and fall-through when it is 1.
- R2: For a conditional relative branch whose displacement is zero or positive, the prediction is fall-through when the flip bit is 0 and taken when it is 1; a zero displacement therefore predicts taken when the flip bit is 1.
- R3: For a conditional register branch (kind 2'b01) whose target is ready, the prediction is fall-through when the flip bit is 0 and taken when it is 1, and the taken address is the register target.
- R4: A conditional register branch whose target is not ready raises waitStall in the same cycle, whatever the flip bit is. It is not accepted and no prediction is produced.
- R5: An unconditional branch (kind 2'b10 or 2'b11) is always predicted taken to brPc plus the sign-extended displacement. It never occupies the reservation slot and never produces a resolve pulse.
- R6: One cycle after a branch is accepted (brValid and brReady, no waitStall, no flush), predValid is high for one cycle. predAddr is the taken target or brPc+4, following predTaken. When predValid is low, predTaken and predAddr are zero.
- R7: A conditional branch is accepted without waiting for its condition and occupies the slot. brReady stays low while the slot is occupied, so no further branch is accepted.
- R8: When condValid is high while the slot is occupied, resolve is high for exactly one cycle in the following cycle and the slot is freed. mispredict is high if condData differs from the prediction. fixAddr is the target if condData is 1 and brPc+4 otherwise, and is zero when resolve is low.
- R9: flush empties the slot with no resolve pulse and blocks acceptance in its own cycle. condValid while the slot is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the reservation slot, block acceptance |
| brValid | input | 1 | Queue head holds a branch |
| brReady | output | 1 | Unit can take a branch (slot free) |
| brKind | input | 2 | 00 conditional relative, 01 conditional register, 1x unconditional |
| brPc | input | ADDR_W | Address of the branch |
| brDisp | input | DISP_W | Signed displacement |
| brOverride | input | 1 | Prediction-flip bit from the instruction |
| regTarget | input | ADDR_W | Register target address |
| regTargetReady | input | 1 | Register target is valid |
| waitStall | output | 1 | Register branch cannot be predicted yet |
| condValid | input | 1 | Condition bit delivered this cycle |
| condData | input | 1 | Condition bit, 1 means taken |
| predValid | output | 1 | Prediction issued this cycle |
| predTaken | output | 1 | Predicted direction |
| predAddr | output | ADDR_W | Predicted next fetch address |
| resolve | output | 1 | Parked branch evaluated |
| mispredict | output | 1 | Evaluation disagrees with the prediction |
| fixAddr | output | ADDR_W | Correct next fetch address on resolve |

## Verification
The assertions assume that brKind, brDisp, brPc and regTarget are stable while brValid is high. They also assume a condition bit is delivered only for the branch currently parked. Nothing on the ports can tell two different conditions apart. The stimulus drives one condition delivery per parked branch and also drops stray deliveries into an empty slot, which R9 says must be ignored. Flushes are mixed in at random, including in the same cycle as acceptances and deliveries.

// File: rtl/brResvPkg.sv
package brResvPkg;

  typedef enum logic [1:0] {
    KIND_REL  = 2'b00,
    KIND_REG  = 2'b01,
    KIND_UNC  = 2'b10,
    KIND_UNCX = 2'b11
  } brKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // branch accepted this cycle
    logic keep;       // accepted branch is conditional: park it
    logic useReg;     // target comes from the register port
    logic predTaken;  // static guess for the accepted branch
    logic resolve;    // parked branch is evaluated this cycle
  } brStrobe_t;

  function automatic logic staticPredict(brKind_e kind, logic dispNeg, logic flip);
    logic guess;
    case (kind)
      KIND_REL: guess = dispNeg ? ~flip : flip;
      KIND_REG: guess = flip;
      default:  guess = 1'b1;
    endcase
    return guess;
  endfunction

endpackage

// File: rtl/brResvCtrl.sv
module brResvCtrl
  import brResvPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flush,
  input  logic       brValid,
  input  logic [1:0] brKind,
  input  logic       dispNeg,
  input  logic       brOverride,
  input  logic       regTargetReady,
  input  logic       condValid,
  output logic       brReady,
  output logic       waitStall,
  output brStrobe_t  strobe
);

  brKind_e kind;
  logic occupied;
  logic accept;
  logic isCond;
  logic resolving;

  assign kind = brKind_e'(brKind);

  always_comb begin
    isCond    = (kind == KIND_REL) || (kind == KIND_REG);
    waitStall = brValid && (kind == KIND_REG) && !regTargetReady;
    brReady   = !occupied;
    accept    = brValid && !occupied && !waitStall && !flush;
    resolving = occupied && condValid && !flush;

    strobe.load      = accept;
    strobe.keep      = accept && isCond;
    strobe.useReg    = (kind == KIND_REG);
    strobe.predTaken = staticPredict(kind, dispNeg, brOverride);
    strobe.resolve   = resolving;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occupied <= 1'b0;
    end else if (flush || resolving) begin
      occupied <= 1'b0;
    end else if (strobe.keep) begin
      occupied <= 1'b1;
    end
  end

  AST_BUSY_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.keep && !flush) |=> !brReady); // R7

endmodule

// File: rtl/brResvPath.sv
module brResvPath
  import brResvPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DISP_W     = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  brStrobe_t         strobe,
  input  logic [ADDR_W-1:0] brPc,
  input  logic [DISP_W-1:0] brDisp,
  input  logic [ADDR_W-1:0] regTarget,
  input  logic              condData,
  output logic              predValid,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predAddr,
  output logic              resolve,
  output logic              mispredict,
  output logic [ADDR_W-1:0] fixAddr
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] relTarget;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] fallAddr;

  logic [ADDR_W-1:0] entTarget;
  logic [ADDR_W-1:0] entFall;
  logic              entPred;

  always_comb begin
    relTarget = brPc + {{EXT_W{brDisp[DISP_W-1]}}, brDisp};
    target    = strobe.useReg ? regTarget : relTarget;
    fallAddr  = brPc + ADDR_W'(INSN_BYTES);
  end

  // Parked entry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entTarget <= '0;
      entFall   <= '0;
      entPred   <= 1'b0;
    end else if (strobe.keep) begin
      entTarget <= target;
      entFall   <= fallAddr;
      entPred   <= strobe.predTaken;
    end
  end

  // Prediction outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid <= 1'b0;
      predTaken <= 1'b0;
      predAddr  <= '0;
    end else begin
      predValid <= strobe.load;
      predTaken <= strobe.load && strobe.predTaken;
      if (!strobe.load) begin
        predAddr <= '0;
      end else if (strobe.predTaken) begin
        predAddr <= target;
      end else begin
        predAddr <= fallAddr;
      end
    end
  end

  // Resolution outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resolve    <= 1'b0;
      mispredict <= 1'b0;
      fixAddr    <= '0;
    end else begin
      resolve    <= strobe.resolve;
      mispredict <= strobe.resolve && (condData != entPred);
      if (!strobe.resolve) begin
        fixAddr <= '0;
      end else if (condData) begin
        fixAddr <= entTarget;
      end else begin
        fixAddr <= entFall;
      end
    end
  end

  AST_RESOLVE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resolve |=> !resolve); // R8

  AST_MISPRED_ON_RESOLVE: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |-> resolve); // R8

endmodule

// File: rtl/brResvUnit.sv
module brResvUnit
  import brResvPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DISP_W     = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              brValid,
  output logic              brReady,
  input  logic [1:0]        brKind,
  input  logic [ADDR_W-1:0] brPc,
  input  logic [DISP_W-1:0] brDisp,
  input  logic              brOverride,
  input  logic [ADDR_W-1:0] regTarget,
  input  logic              regTargetReady,
  output logic              waitStall,
  input  logic              condValid,
  input  logic              condData,
  output logic              predValid,
  output logic              predTaken,
  output logic [ADDR_W-1:0] predAddr,
  output logic              resolve,
  output logic              mispredict,
  output logic [ADDR_W-1:0] fixAddr
);

  brStrobe_t strobe;

  brResvCtrl uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .flush          (flush),
    .brValid        (brValid),
    .brKind         (brKind),
    .dispNeg        (brDisp[DISP_W-1]),
    .brOverride     (brOverride),
    .regTargetReady (regTargetReady),
    .condValid      (condValid),
    .brReady        (brReady),
    .waitStall      (waitStall),
    .strobe         (strobe)
  );

  brResvPath #(
    .ADDR_W     (ADDR_W),
    .DISP_W     (DISP_W),
    .INSN_BYTES (INSN_BYTES)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .brPc       (brPc),
    .brDisp     (brDisp),
    .regTarget  (regTarget),
    .condData   (condData),
    .predValid  (predValid),
    .predTaken  (predTaken),
    .predAddr   (predAddr),
    .resolve    (resolve),
    .mispredict (mispredict),
    .fixAddr    (fixAddr)
  );

  AST_WAIT_NO_PRED: assert property (@(posedge clk) disable iff (!rstN)
    waitStall |=> !predValid); // R4

  AST_UNCOND_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && brReady && brKind[1] && !flush) |=> (predValid && predTaken)); // R5

  AST_PRED_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> $past(brValid && brReady && !flush)); // R6

  AST_FLUSH_NO_RESOLVE: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !resolve); // R9

endmodule

// File: tb/brResvUnit_test.sv
module brResvUnit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        brValid = 1'b0;
  logic [1:0]  brKind = 2'b00;
  logic [31:0] brPc = '0;
  logic [15:0] brDisp = '0;
  logic        brOverride = 1'b0;
  logic [31:0] regTarget = '0;
  logic        regTargetReady = 1'b0;
  logic        condValid = 1'b0;
  logic        condData = 1'b0;

  logic        brReady, waitStall, predValid, predTaken, resolve, mispredict;
  logic [31:0] predAddr, fixAddr;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit          mOcc = 0;
  bit          mPred = 0;
  logic [31:0] mTgt = '0;
  logic [31:0] mFall = '0;
  bit          ePredValid = 0, ePredTaken = 0, eResolve = 0, eMis = 0;
  logic [31:0] ePredAddr = '0, eFix = '0;

  always #4 clk = ~clk;

  brResvUnit uut (
    .clk(clk), .rstN(rstN), .flush(flush), .brValid(brValid), .brReady(brReady),
    .brKind(brKind), .brPc(brPc), .brDisp(brDisp), .brOverride(brOverride),
    .regTarget(regTarget), .regTargetReady(regTargetReady), .waitStall(waitStall),
    .condValid(condValid), .condData(condData), .predValid(predValid),
    .predTaken(predTaken), .predAddr(predAddr), .resolve(resolve),
    .mispredict(mispredict), .fixAddr(fixAddr)
  );

  task automatic chk(string tag, string name, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, name, act, exp);
    end
  endtask

  task automatic checkRegs(string tag);
    chk(tag, "predValid", 32'(predValid), 32'(ePredValid));
    chk(tag, "predTaken", 32'(predTaken), 32'(ePredTaken));
    chk(tag, "predAddr", predAddr, ePredAddr);
    chk(tag, "resolve", 32'(resolve), 32'(eResolve));
    chk(tag, "mispredict", 32'(mispredict), 32'(eMis));
    chk(tag, "fixAddr", fixAddr, eFix);
  endtask

  // One cycle: inputs already set at a falling edge
  task automatic tick(string tag);
    bit expWait, expReady, acc, pred, resolving;
    logic [31:0] tgt, fall;
    #1;
    expWait  = brValid && (brKind == 2'b01) && !regTargetReady;
    expReady = !mOcc;
    chk(tag, "waitStall", 32'(waitStall), 32'(expWait));
    chk(tag, "brReady", 32'(brReady), 32'(expReady));
    acc = brValid && !mOcc && !expWait && !flush;
    if (brKind == 2'b00) pred = brDisp[15] ? !brOverride : brOverride;
    else if (brKind == 2'b01) pred = brOverride;
    else pred = 1;
    tgt  = (brKind == 2'b01) ? regTarget : brPc + {{16{brDisp[15]}}, brDisp};
    fall = brPc + 32'd4;
    resolving = mOcc && condValid && !flush;
    @(posedge clk);
    ePredValid = acc;
    ePredTaken = acc && pred;
    ePredAddr  = acc ? (pred ? tgt : fall) : '0;
    eResolve   = resolving;
    eMis       = resolving && (condData != mPred);
    eFix       = resolving ? (condData ? mTgt : mFall) : '0;
    if (flush || resolving) mOcc = 0;
    else if (acc && !brKind[1]) begin
      mOcc = 1; mPred = pred; mTgt = tgt; mFall = fall;
    end
    @(negedge clk);
    checkRegs(tag);
  endtask

  task automatic idle();
    brValid = 0; condValid = 0; flush = 0;
  endtask

  task automatic offer(logic [1:0] k, logic [31:0] pc, logic [15:0] d, bit ov,
                       logic [31:0] rt, bit rr);
    brValid = 1; brKind = k; brPc = pc; brDisp = d; brOverride = ov;
    regTarget = rt; regTargetReady = rr; condValid = 0; flush = 0;
  endtask

  task automatic deliver(bit c);
    idle(); condValid = 1; condData = c;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkRegs("reset");
    chk("reset", "brReady", 32'(brReady), 32'd1);
    rstN = 1;

    // R1: negative displacement, flip 0 taken; resolve correct (R8)
    offer(2'b00, 32'h1000, 16'hFFF0, 0, '0, 0); tick("R1");
    idle(); tick("R7 busy");
    offer(2'b10, 32'h2000, 16'h0010, 0, '0, 0); tick("R7 blocked");
    deliver(1); tick("R8");
    idle(); tick("R8 done");
    // R1: flip 1 fall-through, mispredict
    offer(2'b00, 32'h1100, 16'h8000, 1, '0, 0); tick("R1");
    deliver(1); tick("R8");
    idle(); tick("R8");
    // R2: positive, flip 0/1 and zero with flip 1
    offer(2'b00, 32'h3000, 16'h0040, 0, '0, 0); tick("R2");
    deliver(0); tick("R2");
    offer(2'b00, 32'h3000, 16'h0040, 1, '0, 0); tick("R2");
    deliver(0); tick("R2");
    offer(2'b00, 32'h3100, 16'h0000, 1, '0, 0); tick("R2 zero");
    deliver(1); tick("R2");
    // R3: register ready
    offer(2'b01, 32'h4000, 16'h0000, 0, 32'hABCD0000, 1); tick("R3");
    deliver(1); tick("R3");
    offer(2'b01, 32'h4000, 16'h0000, 1, 32'hABCD0100, 1); tick("R3");
    deliver(0); tick("R3");
    // R4: not ready, both flip values, then ready
    offer(2'b01, 32'h5000, 16'h0000, 0, 32'h5555, 0); tick("R4");
    offer(2'b01, 32'h5000, 16'h0000, 1, 32'h5555, 0); tick("R4");
    regTargetReady = 1; tick("R4 release");
    deliver(1); tick("R4");
    // R5: unconditional stays out of the slot
    offer(2'b10, 32'h6000, 16'hFF00, 1, '0, 0); tick("R5");
    offer(2'b11, 32'h6100, 16'h0100, 0, '0, 0); tick("R5");
    deliver(1); tick("R5 no resolve");
    idle(); tick("R6");
    // R9: flush
    offer(2'b00, 32'h7000, 16'h0020, 0, '0, 0); tick("R9 park");
    idle(); flush = 1; tick("R9 flush");
    deliver(1); tick("R9 empty cond");
    offer(2'b00, 32'h7100, 16'h0020, 0, '0, 0); flush = 1; tick("R9 flush accept");
    offer(2'b00, 32'h7200, 16'h0020, 0, '0, 0); tick("R9");
    deliver(1); flush = 1; tick("R9 flush resolve");
    idle(); tick("R9");

    // random traffic
    for (int i = 0; i < 2000; i++) begin
      brValid        = ($urandom_range(0, 3) != 0);
      brKind         = 2'($urandom_range(0, 3));
      brPc           = $urandom & 32'hFFFFFFFC;
      brDisp         = ($urandom_range(0, 7) == 0) ? 16'h0 : 16'($urandom);
      brOverride     = 1'($urandom_range(0, 1));
      regTarget      = $urandom;
      regTargetReady = ($urandom_range(0, 3) != 0);
      condValid      = ($urandom_range(0, 2) == 0);
      condData       = 1'($urandom_range(0, 1));
      flush          = ($urandom_range(0, 15) == 0);
      tick("rand R6 R8");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule